// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block gives the two ports of a shared dual-port memory a way to signal each other. It observes the address and access strobes of both ports. The two topmost words of the configured address space serve as mailboxes. The very top word belongs to the right port, and the word just below it belongs to the left port. When one port writes into the other port's mailbox, an interrupt flag is raised toward the receiving port. The receiving port drops that flag by reading its own mailbox word.

The mailbox data itself is held in the ordinary memory array, which sits outside this block. The block only watches accesses and drives two active-low interrupt lines. A depth-select input chooses how many address bits are in use. The mailbox addresses therefore move with the configured depth.

Top module: `mbx_irq_unit`

## Requirements
- R1: A left-port write (cs=1, wr=1) to the highest address sets the right flag, so irq_r_n reads 0 from the cycle after the write edge.
- R2: A right-port write (cs=1, wr=1) to the second-highest address sets the left flag, so irq_l_n reads 0 from the cycle after the write edge.
- R3: A right-port read (cs=1, rd=1, wr=0) of the highest address clears the right flag, so irq_r_n reads 1 from the cycle after.
- R4: A left-port read (cs=1, rd=1, wr=0) of the second-highest address clears the left flag, so irq_l_n reads 1 from the cycle after.
- R5: When a set and a clear reach the same flag on the same edge, the flag ends up set.
- R6: While reset is asserted and right after it, both interrupt outputs read 1. A flag holds its value on every edge that carries neither a set nor a clear.
- R7: depth_sel picks the address width: code 0 gives 12 bits (mailboxes 0xFFF and 0xFFE), code 1 gives 13 bits (0x1FFF and 0x1FFE), code 2 gives 14 bits (0x3FFF and 0x3FFE), and code 3 behaves like code 2. An address matches a mailbox only if all of its bits above the selected width are zero.
- R8: Other accesses change neither flag. This covers a port writing its own mailbox, a port reading the other port's mailbox, any strobe with cs=0, and a read strobe raised together with wr=1 (that access counts as a write).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| depth_sel | input | 2 | Address width select code |
| l_addr | input | 14 | Left-port word address |
| l_cs | input | 1 | Left-port access enable |
| l_wr | input | 1 | Left-port write strobe |
| l_rd | input | 1 | Left-port read strobe |
| r_addr | input | 14 | Right-port word address |
| r_cs | input | 1 | Right-port access enable |
| r_wr | input | 1 | Right-port write strobe |
| r_rd | input | 1 | Right-port read strobe |
| irq_l_n | output | 1 | Active-low interrupt toward the left port |
| irq_r_n | output | 1 | Active-low interrupt toward the right port |

## Verification
The bench uses the default parameters: a 14-bit address bus, a 12-bit minimum width and a 2-bit select code. With these values all three depths and the clamped fourth code can be reached. The bench can then show that a mailbox address valid at a small depth does not match at a larger one. It can also show that a set bit above the selected width blocks a match. Collisions between the two ports are driven directly, and so are the ignored access forms.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    // Decoded mailbox events of one port for one cycle
    typedef struct packed {
        logic wr_top;   // write to highest word
        logic wr_sub;   // write to second-highest word
        logic rd_top;   // read of highest word
        logic rd_sub;   // read of second-highest word
    } mbx_evt_t;

    typedef struct packed {
        logic pend;
    } flag_state_t;

endpackage

// File: rtl/mbx_addr_match.sv
module mbx_addr_match
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int MIN_AW = 12,
    parameter int SEL_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  depth_sel,
    input  logic              cs,
    input  logic              wr,
    input  logic              rd,
    output mbx_evt_t          evt
);
    localparam int NUM_DEPTHS = ADDR_W - MIN_AW + 1;
    localparam int SEL_MAX    = NUM_DEPTHS - 1;

    logic [NUM_DEPTHS-1:0] top_vec;
    logic [NUM_DEPTHS-1:0] sub_vec;

    for (genvar g = 0; g < NUM_DEPTHS; g++) begin : g_depth
        localparam int              AW     = MIN_AW + g;
        localparam logic [ADDR_W:0] SHIFT1 = (ADDR_W+1)'(1) << AW;
        localparam logic [ADDR_W-1:0] TOP  = ADDR_W'(SHIFT1 - (ADDR_W+1)'(1));
        localparam logic [ADDR_W-1:0] SUB  = TOP - ADDR_W'(1);
        assign top_vec[g] = (addr == TOP);
        assign sub_vec[g] = (addr == SUB);
    end

    logic [SEL_W-1:0] sel_c;
    logic             hit_top;
    logic             hit_sub;
    logic             is_wr;
    logic             is_rd;

    always_comb begin
        sel_c = (32'(depth_sel) > SEL_MAX) ? SEL_W'(SEL_MAX) : depth_sel;
        hit_top = 1'b0;
        hit_sub = 1'b0;
        for (int i = 0; i < NUM_DEPTHS; i++) begin
            if (32'(sel_c) == i) begin
                hit_top = top_vec[i];
                hit_sub = sub_vec[i];
            end
        end
        is_wr = cs & wr;
        is_rd = cs & rd & ~wr;
        evt.wr_top = is_wr & hit_top;
        evt.wr_sub = is_wr & hit_sub;
        evt.rd_top = is_rd & hit_top;
        evt.rd_sub = is_rd & hit_sub;
    end

    // R7/R8: one address never hits both mailbox words
    always_comb begin
        assert (!(hit_top && hit_sub)) else $error("a_r7_single_hit");
    end

endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag
    import mbx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pending
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) st_d.pend = 1'b0;
        if (set) st_d.pend = 1'b1;   // set has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;

    a_r6_reset_idle: assert property (@(posedge clk) !rst_n |-> !st_q.pend);
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set && clr) |=> st_q.pend);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(st_q.pend));

endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
    import mbx_irq_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int MIN_AW = 12,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  depth_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_cs,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_cs,
    input  logic              r_wr,
    input  logic              r_rd,
    output logic              irq_l_n,
    output logic              irq_r_n
);
    mbx_evt_t l_evt, r_evt;
    logic     l_pend, r_pend;

    mbx_addr_match #(.ADDR_W(ADDR_W), .MIN_AW(MIN_AW), .SEL_W(SEL_W)) u_l_match (
        .addr(l_addr), .depth_sel(depth_sel), .cs(l_cs), .wr(l_wr), .rd(l_rd), .evt(l_evt)
    );
    mbx_addr_match #(.ADDR_W(ADDR_W), .MIN_AW(MIN_AW), .SEL_W(SEL_W)) u_r_match (
        .addr(r_addr), .depth_sel(depth_sel), .cs(r_cs), .wr(r_wr), .rd(r_rd), .evt(r_evt)
    );

    // right flag: raised by left writing top word, dropped by right reading it
    mbx_irq_flag u_r_flag (
        .clk(clk), .rst_n(rst_n), .set(l_evt.wr_top), .clr(r_evt.rd_top), .pending(r_pend)
    );
    // left flag: raised by right writing second word, dropped by left reading it
    mbx_irq_flag u_l_flag (
        .clk(clk), .rst_n(rst_n), .set(r_evt.wr_sub), .clr(l_evt.rd_sub), .pending(l_pend)
    );

    assign irq_r_n = ~r_pend;
    assign irq_l_n = ~l_pend;

    a_r1_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
        l_evt.wr_top |=> !irq_r_n);
    a_r2_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
        r_evt.wr_sub |=> !irq_l_n);
    a_r3_right_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (r_evt.rd_top && !l_evt.wr_top) |=> irq_r_n);
    a_r4_left_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (l_evt.rd_sub && !r_evt.wr_sub) |=> irq_l_n);
    a_r8_right_only_by_left: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_r_n) |-> $past(l_evt.wr_top));
    a_r8_left_only_by_right: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_l_n) |-> $past(r_evt.wr_sub));

endmodule

// File: tb/tb_mbx_irq_unit.sv
`timescale 1ns/1ps
module tb_mbx_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  depth_sel = 2'd0;
    logic [13:0] l_addr = '0, r_addr = '0;
    logic        l_cs = 0, l_wr = 0, l_rd = 0, r_cs = 0, r_wr = 0, r_rd = 0;
    logic        irq_l_n, irq_r_n;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    mbx_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel),
        .l_addr(l_addr), .l_cs(l_cs), .l_wr(l_wr), .l_rd(l_rd),
        .r_addr(r_addr), .r_cs(r_cs), .r_wr(r_wr), .r_rd(r_rd),
        .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of access from the falling edge, return at the next falling edge
    task automatic step(input logic [13:0] la, input logic lc, lw, lr,
                        input logic [13:0] ra, input logic rc, rw, rr);
        l_addr = la; l_cs = lc; l_wr = lw; l_rd = lr;
        r_addr = ra; r_cs = rc; r_wr = rw; r_rd = rr;
        @(posedge clk);
        @(negedge clk);
        l_cs = 0; l_wr = 0; l_rd = 0; r_cs = 0; r_wr = 0; r_rd = 0;
    endtask

    task automatic idle();
        step('0, 0, 0, 0, '0, 0, 0, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R6 reset irq_l_n", irq_l_n, 1'b1);
        chk("R6 reset irq_r_n", irq_r_n, 1'b1);
        rst_n = 1'b1;
        idle();
        chk("R6 after reset irq_r_n", irq_r_n, 1'b1);
    endtask

    task automatic t_left_to_right();
        depth_sel = 2'd0;
        step(14'h0FFF, 1, 1, 0, '0, 0, 0, 0);
        chk("R1 set right", irq_r_n, 1'b0);
        chk("R1 left untouched", irq_l_n, 1'b1);
        idle();
        chk("R6 hold right", irq_r_n, 1'b0);
        step('0, 0, 0, 0, 14'h0FFF, 1, 0, 1);
        chk("R3 clear right", irq_r_n, 1'b1);
    endtask

    task automatic t_right_to_left();
        depth_sel = 2'd1;
        step('0, 0, 0, 0, 14'h1FFE, 1, 1, 0);
        chk("R2 set left", irq_l_n, 1'b0);
        chk("R2 right untouched", irq_r_n, 1'b1);
        step(14'h1FFE, 1, 0, 1, '0, 0, 0, 0);
        chk("R4 clear left", irq_l_n, 1'b1);
    endtask

    task automatic t_depth();
        depth_sel = 2'd2;
        step(14'h0FFF, 1, 1, 0, '0, 0, 0, 0);
        chk("R7 small top ignored at depth 2", irq_r_n, 1'b1);
        step(14'h3FFF, 1, 1, 0, '0, 0, 0, 0);
        chk("R7 depth 2 top", irq_r_n, 1'b0);
        step('0, 0, 0, 0, 14'h3FFF, 1, 0, 1);
        chk("R7 depth 2 clear", irq_r_n, 1'b1);
        depth_sel = 2'd3;
        step('0, 0, 0, 0, 14'h3FFE, 1, 1, 0);
        chk("R7 code 3 as code 2", irq_l_n, 1'b0);
        step(14'h3FFE, 1, 0, 1, '0, 0, 0, 0);
        chk("R7 code 3 clear", irq_l_n, 1'b1);
        depth_sel = 2'd0;
        step(14'h2FFF, 1, 1, 0, '0, 0, 0, 0);
        chk("R7 high bit blocks match", irq_r_n, 1'b1);
    endtask

    task automatic t_ignored();
        depth_sel = 2'd0;
        step(14'h0FFE, 1, 1, 0, 14'h0FFF, 1, 1, 0);
        chk("R8 own-mailbox writes left", irq_l_n, 1'b1);
        chk("R8 own-mailbox writes right", irq_r_n, 1'b1);
        step(14'h0FFF, 0, 1, 0, 14'h0FFE, 0, 1, 0);
        chk("R8 no cs right", irq_r_n, 1'b1);
        chk("R8 no cs left", irq_l_n, 1'b1);
        step(14'h0FFF, 1, 1, 0, 14'h0FFE, 1, 1, 0);
        chk("R8 setup right", irq_r_n, 1'b0);
        chk("R8 setup left", irq_l_n, 1'b0);
        step(14'h0FFF, 1, 0, 1, 14'h0FFE, 1, 0, 1);
        chk("R8 cross reads right", irq_r_n, 1'b0);
        chk("R8 cross reads left", irq_l_n, 1'b0);
        step(14'h0FFE, 1, 1, 1, 14'h0FFF, 1, 1, 1);
        chk("R8 rd with wr right", irq_r_n, 1'b0);
        chk("R8 rd with wr left", irq_l_n, 1'b0);
        step(14'h0FFE, 0, 0, 1, 14'h0FFF, 0, 0, 1);
        chk("R8 read no cs right", irq_r_n, 1'b0);
        step(14'h0FFE, 1, 0, 1, 14'h0FFF, 1, 0, 1);
        chk("R3 final clear right", irq_r_n, 1'b1);
        chk("R4 final clear left", irq_l_n, 1'b1);
    endtask

    task automatic t_collision();
        depth_sel = 2'd1;
        step(14'h1FFF, 1, 1, 0, 14'h1FFF, 1, 0, 1);
        chk("R5 right set wins", irq_r_n, 1'b0);
        step(14'h1FFE, 1, 0, 1, 14'h1FFE, 1, 1, 0);
        chk("R5 left set wins", irq_l_n, 1'b0);
        step(14'h1FFE, 1, 0, 1, 14'h1FFF, 1, 0, 1);
        chk("R5 later clear right", irq_r_n, 1'b1);
        chk("R5 later clear left", irq_l_n, 1'b1);
    endtask

    initial begin
        t_reset();
        t_left_to_right();
        t_right_to_left();
        t_depth();
        t_ignored();
        t_collision();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule